// File: doc/BRIEF.md
# Two-Channel Join Adder

The block takes two 32-bit operands from two separate valid/ready input channels and delivers their sum on a valid/ready output channel. Each operand is taken in on its own, whenever its handshake completes, into a holding slot with an occupancy flag. The two operands therefore never need to be offered in the same cycle, and they may arrive in either order.

Once both slots are occupied, the sum is presented on the output. It is held steady until the receiver takes it. In the cycle that the output handshake completes, both slots empty together, and both input channels become ready again. Message bits on an input that is not valid can never reach the sum, because a slot loads only on a completed handshake. A synchronous active-low reset empties both slots.

Top module: `join_adder`

## Requirements
- R1: After reset, and whenever a slot is empty, that input's ready is high. While its slot is occupied, that input's ready is low.
- R2: A slot loads only in a cycle where that input's valid and ready are both high. It holds the message present in that cycle.
- R3: While a slot is occupied, any valid/message activity on that input has no effect on the slot's value.
- R4: Output valid is high exactly when both slots are occupied. It rises in the cycle after the second operand is accepted.
- R5: The output message equals (operand A + operand B) modulo 2^32.
- R6: While output valid is high and output ready is low, output valid stays high and the output message stays unchanged.
- R7: In the cycle the output handshake completes, both slots empty. In the next cycle both input readies are high and output valid is low.
- R8: Input message bits presented while that input's valid is low never affect any output value.
- R9: A synchronous active-low reset empties both slots, so output valid is low. An operand held before reset is discarded.
- R10: The two operands may be accepted in different cycles and in either order, with the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_msg | input | 32 | Operand A message |
| a_vld | input | 1 | Operand A valid |
| a_rdy | output | 1 | Operand A ready (slot A empty) |
| b_msg | input | 32 | Operand B message |
| b_vld | input | 1 | Operand B valid |
| b_rdy | output | 1 | Operand B ready (slot B empty) |
| s_msg | output | 32 | Sum message |
| s_vld | output | 1 | Sum valid |
| s_rdy | input | 1 | Sum ready from the receiver |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the output handshake and a new operand being offered. The bench keeps an input valid asserted with fresh data while the sum is being accepted. It then checks that the new operand is not taken in that cycle, and that it lands only after the readies return, producing the next sum correctly.

The second pair is the acceptance of both operands in one cycle. Vectors with equal input delays provoke this, and the sum must appear exactly one cycle later.

Throughout all of this, the inputs carry scrambled message bits whenever their valid is low. The sum is judged against an independently computed modular addition.

// File: rtl/join_adder_pkg.sv
// Package: shared widths and slot indices for the two-channel join adder.
package join_adder_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned N_PORTS = 2;
    localparam int unsigned IDX_A   = 0;
    localparam int unsigned IDX_B   = 1;
endpackage

// File: rtl/operand_slot.sv
// Operand slot: a one-entry holding register with an occupancy flag.
// Loads in_msg only on a completed handshake (in_vld & in_rdy); ready is the
// inverse of occupancy. Empties when drain is high. Assumes drain is raised
// only while the slot is occupied.
module operand_slot #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_msg,
    input  logic         in_vld,
    output logic         in_rdy,
    input  logic         drain,
    output logic         held,
    output logic [W-1:0] held_msg
);
    logic         full_q;
    logic [W-1:0] data_q;
    logic         take;

    // Handshake detection: ready only while empty.
    always_comb begin
        in_rdy = ~full_q;
        take   = in_vld & in_rdy;
    end

    // Occupancy flag: set on a taken operand, cleared on drain or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     full_q <= 1'b0;
        else if (drain) full_q <= 1'b0;
        else if (take)  full_q <= 1'b1;
    end

    // Data register: loads only on a taken operand, otherwise holds.
    always_ff @(posedge clk) begin
        if (take) data_q <= in_msg;
    end

    assign held     = full_q;
    assign held_msg = data_q;

    // R2: a completed handshake fills the slot with that cycle's message.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_rdy && !drain) |=> (full_q && data_q == $past(in_msg)));

    // R3: an occupied slot keeps its value until drained.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !drain) |=> (full_q && $stable(data_q)));

    // R8: with no valid, an empty slot stays empty.
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_q && !in_vld) |=> !full_q);
endmodule

// File: rtl/sum_unit.sv
// Sum unit: wrapping adder of two W-bit operands, result modulo 2^W.
// Purely combinational; assumes operands are stable while they are used.
module sum_unit #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    output logic [W-1:0] total
);
    // Modular addition: carry out of the top bit is discarded.
    always_comb begin
        total = op_x + op_y;
    end
endmodule

// File: rtl/join_adder.sv
// Two-channel join adder: collects one operand per input channel into
// independent slots and presents their wrapping sum once both are held.
// Both slots empty on the output handshake. Assumes a receiver that obeys
// valid/ready (data taken when s_vld & s_rdy).
module join_adder
    import join_adder_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_msg,
    input  logic         a_vld,
    output logic         a_rdy,
    input  logic [W-1:0] b_msg,
    input  logic         b_vld,
    output logic         b_rdy,
    output logic [W-1:0] s_msg,
    output logic         s_vld,
    input  logic         s_rdy
);
    logic [W-1:0] port_msg  [N_PORTS];
    logic         port_vld  [N_PORTS];
    logic         port_rdy  [N_PORTS];
    logic         port_held [N_PORTS];
    logic [W-1:0] port_data [N_PORTS];
    logic         both_held;
    logic         release_now;

    // Input mapping: gather the two channels into indexed arrays.
    always_comb begin
        port_msg[IDX_A] = a_msg;
        port_vld[IDX_A] = a_vld;
        port_msg[IDX_B] = b_msg;
        port_vld[IDX_B] = b_vld;
    end

    for (genvar i = 0; i < N_PORTS; i++) begin : g_slot
        operand_slot #(.W(W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_msg   (port_msg[i]),
            .in_vld   (port_vld[i]),
            .in_rdy   (port_rdy[i]),
            .drain    (release_now),
            .held     (port_held[i]),
            .held_msg (port_data[i])
        );
    end

    // Join condition and output handshake.
    always_comb begin
        both_held   = port_held[IDX_A] & port_held[IDX_B];
        release_now = both_held & s_rdy;
    end

    sum_unit #(.W(W)) u_sum (
        .op_x  (port_data[IDX_A]),
        .op_y  (port_data[IDX_B]),
        .total (s_msg)
    );

    assign s_vld = both_held;
    assign a_rdy = port_rdy[IDX_A];
    assign b_rdy = port_rdy[IDX_B];

    // R4: a valid sum implies neither input is accepting.
    p_join_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_vld |-> (!a_rdy && !b_rdy));

    // R6: a stalled sum stays valid and unchanged.
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && !s_rdy) |=> (s_vld && $stable(s_msg)));

    // R7: the output handshake empties both slots together.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_rdy) |=> (a_rdy && b_rdy && !s_vld));
endmodule

// File: tb/tb_join_adder.sv
module tb_join_adder;
    localparam int W = 32;
    localparam int NV = 8;
    // Vector: {a, b, delay_a, delay_b, stall}
    localparam logic [W*2+11:0] VEC [NV] = '{
        {32'h0000_0001, 32'h0000_0002, 4'd0, 4'd0, 4'd0},
        {32'hFFFF_FFFF, 32'h0000_0001, 4'd0, 4'd3, 4'd1},
        {32'h1234_5678, 32'h8765_4321, 4'd4, 4'd0, 4'd0},
        {32'h8000_0000, 32'h8000_0000, 4'd2, 4'd2, 4'd3},
        {32'hDEAD_BEEF, 32'h0BAD_F00D, 4'd1, 4'd6, 4'd2},
        {32'h0000_0000, 32'h0000_0000, 4'd5, 4'd1, 4'd0},
        {32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'd0, 4'd1, 4'd5},
        {32'hA5A5_A5A5, 32'h5A5A_5A5A, 4'd3, 4'd3, 4'd1}
    };

    logic         clk = 0;
    logic         rst_n = 0;
    logic [W-1:0] a_msg = '0, b_msg = '0, s_msg;
    logic         a_vld = 0, b_vld = 0, s_rdy = 0;
    logic         a_rdy, b_rdy, s_vld;
    int           n_run = 0, n_fail = 0;
    logic [W-1:0] got;

    always #4 clk = ~clk;

    join_adder #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_msg(a_msg), .a_vld(a_vld), .a_rdy(a_rdy),
        .b_msg(b_msg), .b_vld(b_vld), .b_rdy(b_rdy),
        .s_msg(s_msg), .s_vld(s_vld), .s_rdy(s_rdy)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offer one operand on A after a delay, with garbage while idle (R8).
    task automatic drive_a(input logic [W-1:0] d, input int dly);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk); a_vld = 0; a_msg = $urandom;
        end
        @(negedge clk); a_vld = 1; a_msg = d;
        while (!a_rdy) @(negedge clk);
        @(posedge clk);
        @(negedge clk); a_vld = 0; a_msg = $urandom;
    endtask

    task automatic drive_b(input logic [W-1:0] d, input int dly);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk); b_vld = 0; b_msg = $urandom;
        end
        @(negedge clk); b_vld = 1; b_msg = d;
        while (!b_rdy) @(negedge clk);
        @(posedge clk);
        @(negedge clk); b_vld = 0; b_msg = $urandom;
    endtask

    // Receive one sum after stalling, checking hold while stalled (R6).
    task automatic take_sum(input int stall, output logic [W-1:0] v);
        logic [W-1:0] first;
        @(negedge clk);
        while (!s_vld) @(negedge clk);
        first = s_msg;
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            check("R6 valid held", {31'd0, s_vld}, 32'd1);
            check("R6 msg stable", s_msg, first);
        end
        s_rdy = 1;
        v = s_msg;
        @(posedge clk);
        @(negedge clk); s_rdy = 0;
        check("R7 a_rdy after release", {31'd0, a_rdy}, 32'd1);
        check("R7 b_rdy after release", {31'd0, b_rdy}, 32'd1);
        check("R7 valid low after release", {31'd0, s_vld}, 32'd0);
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9/R1: reset state
        check("R9 valid after reset", {31'd0, s_vld}, 32'd0);
        check("R1 a_rdy after reset", {31'd0, a_rdy}, 32'd1);
        check("R1 b_rdy after reset", {31'd0, b_rdy}, 32'd1);
        rst_n = 1;

        // R5/R10/R8: vector table
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] va, vb;
            int da, db, st;
            {va, vb, da, db, st} = {VEC[i][W*2+11:12], 4'd0, 4'd0, 4'd0} >> 12;
            va = VEC[i][W*2+11:W+12];
            vb = VEC[i][W+11:12];
            da = int'(VEC[i][11:8]);
            db = int'(VEC[i][7:4]);
            st = int'(VEC[i][3:0]);
            fork
                drive_a(va, da);
                drive_b(vb, db);
                take_sum(st, got);
            join
            check($sformatf("R5 R10 sum vector %0d", i), got, va + vb);
        end

        // R4/R1/R3: A alone gives no sum; A ready low; extra A data ignored
        drive_a(32'h0000_0010, 0);
        check("R1 a_rdy low while held", {31'd0, a_rdy}, 32'd0);
        @(negedge clk); a_vld = 1; a_msg = 32'hFFFF_0000;
        repeat (4) @(negedge clk);
        check("R4 no sum with one operand", {31'd0, s_vld}, 32'd0);
        // keep A offering during the next handshake (same-cycle case)
        fork
            drive_b(32'h0000_0020, 1);
            take_sum(0, got);
        join
        check("R3 held A not overwritten", got, 32'h0000_0030);
        // the still-offered A is taken after readies return
        @(negedge clk); a_vld = 0; a_msg = $urandom;
        fork
            drive_b(32'h0000_0001, 0);
            take_sum(0, got);
        join
        check("R3 R7 pending A accepted after release", got, 32'hFFFF_0001);

        // R4 timing: both accepted together, sum valid one cycle later
        @(negedge clk); a_vld = 1; b_vld = 1; a_msg = 32'd7; b_msg = 32'd9;
        @(posedge clk);
        @(negedge clk); a_vld = 0; b_vld = 0; a_msg = $urandom; b_msg = $urandom;
        check("R4 valid one cycle after join", {31'd0, s_vld}, 32'd1);
        check("R5 joined sum", s_msg, 32'd16);
        s_rdy = 1; @(posedge clk); @(negedge clk); s_rdy = 0;

        // R9: reset discards a held operand
        drive_a(32'h0000_0100, 0);
        @(negedge clk); rst_n = 0;
        @(posedge clk); @(negedge clk); rst_n = 1;
        check("R9 a_rdy after mid reset", {31'd0, a_rdy}, 32'd1);
        drive_b(32'h0000_0005, 0);
        repeat (3) @(negedge clk);
        check("R9 held A dropped by reset", {31'd0, s_vld}, 32'd0);
        fork
            drive_a(32'h0000_0003, 0);
            take_sum(0, got);
        join
        check("R9 fresh sum after reset", got, 32'h0000_0008);

        // R8: long garbage with valid low produces nothing
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); a_msg = $urandom; b_msg = $urandom;
        end
        check("R8 no sum from invalid data", {31'd0, s_vld}, 32'd0);
        check("R8 a still empty", {31'd0, a_rdy}, 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule